// File: doc/BRIEF.md
# Pipelined Bus Window Decoder

This block joins one bus master to four slaves on a pipelined, strobe-and-acknowledge bus with a stall signal and 16-bit data. The two most significant bits of the master's 20-bit word address choose one of four equal windows of 256K words each. The remaining 18 bits go unchanged to every slave, together with write enable and write data. Only the chosen slave sees its strobe. A slave that decodes fewer address bits therefore appears repeated across its whole window. A window can be closed off by tying its slave to a constant acknowledge, zero read data and no stall. The window then reads as zero and ignores writes.

The master can have several requests in flight. The slave index of every accepted request goes into a small in-order owner queue. The oldest entry decides whose acknowledge and read data reach the master. A slave can only answer in its own order, so the block holds the master in stall rather than send a request to a different slave while answers are still due from another one. This keeps responses in request order. Dropping the cycle signal empties the queue, and acknowledges that arrive after that are discarded. One clock and one reset come in and are fanned out unchanged to the master and to all four slaves.

Top module: `pbus_interconnect`

## Requirements
- R1: The slave strobe `s_stb_o[i]` is high only when `m_cyc_i` and `m_stb_i` are both high, `m_adr_i[19:18]` equals `i`, and the block is not holding the request back (R9, R10). All other slave strobes stay low.
- R2: Every slave receives `m_adr_i[17:0]` on its 18-bit slice `s_adr_o[18*i +: 18]`, the master write data on `s_wdat_o[16*i +: 16]` and `m_we_i` on `s_we_o[i]`, all in the same cycle. Master addresses that differ only in bits a slave does not decode reach the same slave location.
- R3: `m_stall_o` is 0 whenever `m_cyc_i` and `m_stb_i` are not both high. While they are, `m_stall_o` follows the addressed slave's `s_stall_i`, and the slave keeps seeing its strobe while it stalls.
- R4: `m_ack_o` and `m_rdat_o` come from the slave that owns the oldest outstanding request. Read data returns to the master in the order the requests were accepted.
- R5: With no outstanding request, `m_ack_o` is 0 whatever the slaves drive. `m_rdat_o` is 0 in every cycle where `m_ack_o` is 0.
- R6: A cycle with `m_cyc_i` low empties the owner queue, and so does a cycle with `rst_i` high (synchronous, active high). Acknowledges for requests accepted before that are ignored.
- R7: `m_clk_o` and every bit of `s_clk_o` equal `clk_i`. `m_rst_o` and every bit of `s_rst_o` equal `rst_i`.
- R8: A slave tied to acknowledge 1, read data 0 and stall 0 makes its window return 0 for every read, and writes to that window have no effect.
- R9: When `DEPTH` (default 4) requests are outstanding, a new request stalls the master and strobes no slave until an acknowledge frees an entry.
- R10: While requests to one slave are outstanding, a request to a different slave stalls the master and strobes no slave until those requests have all been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared bus clock |
| rst_i | input | 1 | Synchronous active-high reset |
| m_clk_o | output | 1 | Clock to the master |
| m_rst_o | output | 1 | Reset to the master |
| m_cyc_i | input | 1 | Master bus cycle active |
| m_stb_i | input | 1 | Master request strobe |
| m_we_i | input | 1 | Master write enable |
| m_adr_i | input | 20 | Master word address; bits 19:18 select the slave |
| m_wdat_i | input | 16 | Master write data |
| m_rdat_o | output | 16 | Read data returned to the master |
| m_ack_o | output | 1 | Acknowledge to the master |
| m_stall_o | output | 1 | Stall to the master |
| s_clk_o | output | 4 | Clock to each slave |
| s_rst_o | output | 4 | Reset to each slave |
| s_stb_o | output | 4 | Strobe to each slave |
| s_we_o | output | 4 | Write enable to each slave |
| s_adr_o | output | 72 | 18-bit word address per slave, slave i at bits 18*i+17:18*i |
| s_wdat_o | output | 64 | Write data per slave, slave i at bits 16*i+15:16*i |
| s_rdat_i | input | 64 | Read data from each slave, same packing |
| s_ack_i | input | 4 | Acknowledge from each slave |
| s_stall_i | input | 4 | Stall from each slave |

## Verification
Strobe, address, write-data and stall decisions are combinational in the cycle a request is presented. The bench drives each request just after a falling edge and samples those outputs half a cycle later, before the rising edge that would accept it. An acknowledge is due a slave-specific number of edges after acceptance: the bench slaves answer after 1, 2 and 6 edges, and the tied-off slave answers in the cycle after acceptance. The bench therefore samples `m_ack_o` and `m_rdat_o` just after every falling edge. It compares each acknowledge against a queue of expected results built at the moment the bench saw the request accepted. The full-queue, slave-switch and flush cases are checked in the exact cycle that they block or discard, by presenting the request and reading the stall and strobes before the next edge.

// File: rtl/pbus_ic_pkg.sv
package pbus_ic_pkg;

   // Power-of-two test used by elaboration checks
   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   // Default geometry of the interconnect
   localparam int unsigned DEF_ADDR_W = 20;
   localparam int unsigned DEF_SEL_W  = 2;
   localparam int unsigned DEF_DATA_W = 16;
   localparam int unsigned DEF_DEPTH  = 4;

endpackage

// File: rtl/pbus_win_decode.sv
module pbus_win_decode #(
   parameter int unsigned ADDR_W = pbus_ic_pkg::DEF_ADDR_W,
   parameter int unsigned SEL_W  = pbus_ic_pkg::DEF_SEL_W,
   localparam int unsigned NUM_SLV = 1 << SEL_W
) (
   input  logic [ADDR_W-1:0]  addr_i,
   output logic [SEL_W-1:0]   idx_o,
   output logic [NUM_SLV-1:0] hit_o
);

   initial begin
      assert (ADDR_W > SEL_W) else $error("window select wider than address");
      assert (SEL_W >= 1) else $error("need at least two windows");
   end

   assign idx_o = addr_i[ADDR_W-1 -: SEL_W];

   for (genvar g = 0; g < NUM_SLV; g++) begin : g_hit
      assign hit_o[g] = (idx_o == SEL_W'(g));
   end

endmodule

// File: rtl/pbus_owner_fifo.sv
module pbus_owner_fifo #(
   parameter int unsigned DEPTH = pbus_ic_pkg::DEF_DEPTH,
   parameter int unsigned IDX_W = pbus_ic_pkg::DEF_SEL_W,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             flush_i,
   input  logic             push_i,
   input  logic [IDX_W-1:0] push_idx_i,
   input  logic             pop_i,
   output logic [IDX_W-1:0] head_idx_o,
   output logic [IDX_W-1:0] tail_idx_o,
   output logic             empty_o,
   output logic             full_o
);

   initial begin
      assert (pbus_ic_pkg::is_pow2(DEPTH)) else $error("DEPTH must be a power of two");
      assert (DEPTH >= 2) else $error("DEPTH must be at least 2");
   end

   logic [IDX_W-1:0] slot_q [DEPTH];
   logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
   logic [CNT_W-1:0] cnt_q;
   logic [PTR_W-1:0] last_ptr;

   assign last_ptr   = wr_ptr_q - PTR_W'(1);
   assign head_idx_o = slot_q[rd_ptr_q];
   assign tail_idx_o = slot_q[last_ptr];
   assign empty_o    = (cnt_q == '0);
   assign full_o     = (cnt_q == CNT_W'(DEPTH));

   always_ff @(posedge clk_i) begin
      if (push_i) slot_q[wr_ptr_q] <= push_idx_i;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i || flush_i) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (push_i) wr_ptr_q <= wr_ptr_q + PTR_W'(1);
         if (pop_i)  rd_ptr_q <= rd_ptr_q + PTR_W'(1);
         case ({push_i, pop_i})
            2'b10:   cnt_q <= cnt_q + CNT_W'(1);
            2'b01:   cnt_q <= cnt_q - CNT_W'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      (full_o && !pop_i) |-> !push_i);

   assert_no_underflow_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      empty_o |-> !pop_i);

   assert_flush_empties_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      flush_i |=> empty_o);

endmodule

// File: rtl/pbus_resp_route.sv
module pbus_resp_route #(
   parameter int unsigned SEL_W  = pbus_ic_pkg::DEF_SEL_W,
   parameter int unsigned DATA_W = pbus_ic_pkg::DEF_DATA_W,
   localparam int unsigned NUM_SLV = 1 << SEL_W
) (
   input  logic                      cyc_i,
   input  logic                      owner_vld_i,
   input  logic [SEL_W-1:0]          owner_i,
   input  logic [NUM_SLV-1:0]        s_ack_i,
   input  logic [NUM_SLV*DATA_W-1:0] s_rdat_i,
   output logic                      ack_o,
   output logic [DATA_W-1:0]         rdat_o
);

   logic [DATA_W-1:0] rdat_sel [NUM_SLV];

   for (genvar g = 0; g < NUM_SLV; g++) begin : g_lane
      assign rdat_sel[g] = s_rdat_i[g*DATA_W +: DATA_W];
   end

   assign ack_o  = cyc_i && owner_vld_i && s_ack_i[owner_i];
   assign rdat_o = ack_o ? rdat_sel[owner_i] : '0;

endmodule

// File: rtl/pbus_interconnect.sv
module pbus_interconnect #(
   parameter int unsigned ADDR_W      = pbus_ic_pkg::DEF_ADDR_W,
   parameter int unsigned SEL_W       = pbus_ic_pkg::DEF_SEL_W,
   parameter int unsigned DATA_W      = pbus_ic_pkg::DEF_DATA_W,
   parameter int unsigned DEPTH       = pbus_ic_pkg::DEF_DEPTH,
   parameter bit          ORDER_GUARD = 1'b1,
   localparam int unsigned NUM_SLV = 1 << SEL_W,
   localparam int unsigned SLV_AW  = ADDR_W - SEL_W
) (
   input  logic                      clk_i,
   input  logic                      rst_i,
   output logic                      m_clk_o,
   output logic                      m_rst_o,
   input  logic                      m_cyc_i,
   input  logic                      m_stb_i,
   input  logic                      m_we_i,
   input  logic [ADDR_W-1:0]         m_adr_i,
   input  logic [DATA_W-1:0]         m_wdat_i,
   output logic [DATA_W-1:0]         m_rdat_o,
   output logic                      m_ack_o,
   output logic                      m_stall_o,
   output logic [NUM_SLV-1:0]        s_clk_o,
   output logic [NUM_SLV-1:0]        s_rst_o,
   output logic [NUM_SLV-1:0]        s_stb_o,
   output logic [NUM_SLV-1:0]        s_we_o,
   output logic [NUM_SLV*SLV_AW-1:0] s_adr_o,
   output logic [NUM_SLV*DATA_W-1:0] s_wdat_o,
   input  logic [NUM_SLV*DATA_W-1:0] s_rdat_i,
   input  logic [NUM_SLV-1:0]        s_ack_i,
   input  logic [NUM_SLV-1:0]        s_stall_i
);

   initial begin
      assert (DATA_W >= 1) else $error("DATA_W must be positive");
      assert (SLV_AW >= 1) else $error("no address bits left for the slaves");
   end

   logic [SEL_W-1:0]   sel;
   logic [NUM_SLV-1:0] hit;
   logic               req, hazard, block, push, flush;
   logic               q_empty, q_full;
   logic [SEL_W-1:0]   q_head, q_tail;

   pbus_win_decode #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_dec (
      .addr_i (m_adr_i),
      .idx_o  (sel),
      .hit_o  (hit)
   );

   assign req = m_cyc_i && m_stb_i;

   if (ORDER_GUARD) begin : g_guard
      assign hazard = !q_empty && (q_tail != sel);
   end else begin : g_noguard
      assign hazard = 1'b0;
   end

   assign block     = q_full || hazard;
   assign s_stb_o   = hit & {NUM_SLV{req && !block}};
   assign m_stall_o = req && (block || s_stall_i[sel]);
   assign push      = req && !m_stall_o;
   assign flush     = !m_cyc_i;

   pbus_owner_fifo #(.DEPTH(DEPTH), .IDX_W(SEL_W)) u_owner (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .flush_i    (flush),
      .push_i     (push),
      .push_idx_i (sel),
      .pop_i      (m_ack_o),
      .head_idx_o (q_head),
      .tail_idx_o (q_tail),
      .empty_o    (q_empty),
      .full_o     (q_full)
   );

   pbus_resp_route #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_route (
      .cyc_i       (m_cyc_i),
      .owner_vld_i (!q_empty),
      .owner_i     (q_head),
      .s_ack_i     (s_ack_i),
      .s_rdat_i    (s_rdat_i),
      .ack_o       (m_ack_o),
      .rdat_o      (m_rdat_o)
   );

   assign m_clk_o = clk_i;
   assign m_rst_o = rst_i;

   for (genvar g = 0; g < NUM_SLV; g++) begin : g_port
      assign s_clk_o[g]                   = clk_i;
      assign s_rst_o[g]                   = rst_i;
      assign s_we_o[g]                    = m_we_i;
      assign s_adr_o[g*SLV_AW +: SLV_AW]  = m_adr_i[SLV_AW-1:0];
      assign s_wdat_o[g*DATA_W +: DATA_W] = m_wdat_i;
   end

   assert_stb_onehot_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0(s_stb_o));

   assert_stb_needs_req_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      (|s_stb_o) |-> (m_cyc_i && m_stb_i));

   assert_idle_no_stall_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      !(m_cyc_i && m_stb_i) |-> !m_stall_o);

   assert_ack_has_owner_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      m_ack_o |-> (!q_empty && m_cyc_i));

   assert_full_blocks_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      q_full |-> (s_stb_o == '0));

   assert_accept_fills_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (push && !m_ack_o) |=> !q_empty);

endmodule

// File: tb/pbus_interconnect_bench.sv
`timescale 1ns/100ps
module pbus_interconnect_bench;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   logic        m_cyc = 0, m_stb = 0, m_we = 0;
   logic [19:0] m_adr = '0;
   logic [15:0] m_wdat = '0;
   logic [15:0] m_rdat;
   logic        m_ack, m_stall, m_clk, m_rst;
   logic [3:0]  s_clk, s_rst, s_stb, s_we, s_ack, s_stall;
   logic [71:0] s_adr;
   logic [63:0] s_wdat, s_rdat;

   pbus_interconnect u_pbus_interconnect (
      .clk_i(clk), .rst_i(rst), .m_clk_o(m_clk), .m_rst_o(m_rst),
      .m_cyc_i(m_cyc), .m_stb_i(m_stb), .m_we_i(m_we), .m_adr_i(m_adr),
      .m_wdat_i(m_wdat), .m_rdat_o(m_rdat), .m_ack_o(m_ack), .m_stall_o(m_stall),
      .s_clk_o(s_clk), .s_rst_o(s_rst), .s_stb_o(s_stb), .s_we_o(s_we),
      .s_adr_o(s_adr), .s_wdat_o(s_wdat), .s_rdat_i(s_rdat),
      .s_ack_i(s_ack), .s_stall_i(s_stall)
   );

   // ---------------- behavioural slaves 0..2, slave 3 tied off ------------
   function automatic int lat(input int i);
      return (i == 0) ? 1 : (i == 1) ? 2 : 6;
   endfunction

   logic [15:0] smem [3][256];
   logic        pv   [3][8];
   logic [15:0] pd   [3][8];
   logic [2:0]  sstall = '0;
   logic [2:0]  force_stall = '0;
   bit          stall_en = 0;

   always @(posedge clk) begin
      for (int i = 0; i < 3; i++) begin
         logic [7:0] a;
         a = s_adr[i*18 +: 8];
         for (int k = 7; k > 0; k--) begin
            pv[i][k] <= rst ? 1'b0 : pv[i][k-1];
            pd[i][k] <= pd[i][k-1];
         end
         if (!rst && s_stb[i] && !sstall[i]) begin
            pv[i][0] <= 1'b1;
            pd[i][0] <= s_we[i] ? 16'h0 : smem[i][a];
            if (s_we[i]) smem[i][a] <= s_wdat[i*16 +: 16];
         end else begin
            pv[i][0] <= 1'b0;
         end
         sstall[i] <= force_stall[i] | (stall_en & ($urandom_range(3) == 0));
      end
   end

   always_comb begin
      for (int i = 0; i < 3; i++) begin
         s_ack[i]          = pv[i][lat(i)-1];
         s_rdat[i*16 +: 16] = pd[i][lat(i)-1];
         s_stall[i]        = sstall[i];
      end
      s_ack[3]       = 1'b1;
      s_rdat[63:48]  = 16'h0;
      s_stall[3]     = 1'b0;
   end

   // ---------------- checking infrastructure ------------------------------
   int vectors = 0;
   int miscompares = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [71:0] act, input logic [71:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   logic [15:0] refm [3][256];
   bit          exp_rd  [256];
   logic [15:0] exp_dat [256];
   int          exp_slv [256];
   int eh = 0, et = 0;

   task automatic check_ack();
      if (m_ack) begin
         if (eh == et) begin
            chk(0, "R5", "ack with nothing outstanding", 72'(m_ack), 72'(0));
         end else begin
            if (exp_rd[eh % 256])
               chk(m_rdat == exp_dat[eh % 256], (exp_slv[eh % 256] == 3) ? "R8" : "R4",
                   "read data order", 72'(m_rdat), 72'(exp_dat[eh % 256]));
            eh++;
         end
      end else if (m_rdat != 16'h0) begin
         chk(0, "R5", "data without ack", 72'(m_rdat), 72'(0));
      end
   endtask

   task automatic step();
      @(negedge clk);
      #0.2;
      check_ack();
   endtask

   task automatic issue(input logic we, input logic [19:0] a, input logic [15:0] d);
      int s;
      s = int'(a[19:18]);
      m_cyc = 1; m_stb = 1; m_we = we; m_adr = a; m_wdat = d;
      forever begin
         #0.5;
         if (!m_stall) begin
            chk(s_stb == 4'(1 << s), "R1", "slave strobe", 72'(s_stb), 72'(1 << s));
            for (int i = 0; i < 4; i++) begin
               chk(s_adr[i*18 +: 18] == a[17:0], "R2", "slave address",
                   72'(s_adr[i*18 +: 18]), 72'(a[17:0]));
               chk(s_we[i] == we && s_wdat[i*16 +: 16] == d, "R2", "write fields",
                   72'({s_we[i], s_wdat[i*16 +: 16]}), 72'({we, d}));
            end
            exp_rd[et % 256]  = !we;
            exp_slv[et % 256] = s;
            exp_dat[et % 256] = (s == 3) ? 16'h0 : refm[s][a[7:0]];
            if (we && s != 3) refm[s][a[7:0]] = d;
            et++;
            step();
            break;
         end
         step();
      end
      m_stb = 0;
   endtask

   task automatic drain();
      for (int n = 0; n < 300 && eh != et; n++) step();
      chk(eh == et, "R4", "all responses returned", 72'(et - eh), 72'(0));
   endtask

   // ---------------- watchdog ---------------------------------------------
   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL R4 watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   // ---------------- stimulus ---------------------------------------------
   initial begin
      // reset and fan-out (R7)
      repeat (2) @(negedge clk);
      #0.2;
      chk(m_rst == 1'b1 && s_rst == 4'hF, "R7", "reset fan-out", 72'({m_rst, s_rst}), 72'(5'h1F));
      chk(m_clk == clk && s_clk == {4{clk}}, "R7", "clock fan-out low", 72'({m_clk, s_clk}), 72'({5{clk}}));
      @(posedge clk); #0.2;
      chk(m_clk == 1'b1 && s_clk == 4'hF, "R7", "clock fan-out high", 72'({m_clk, s_clk}), 72'(5'h1F));
      @(negedge clk); rst = 0;
      step();
      chk(m_rst == 1'b0 && s_rst == 4'h0, "R7", "reset released", 72'({m_rst, s_rst}), 72'(0));
      chk(!m_ack && !m_stall && s_stb == 0 && m_rdat == 0, "R6", "idle after reset",
          72'({m_ack, m_stall, s_stb, m_rdat}), 72'(0));

      // strobe without cycle (R1, R3)
      m_stb = 1; m_adr = 20'h40010; #0.5;
      chk(s_stb == 0, "R1", "no strobe without cycle", 72'(s_stb), 72'(0));
      chk(!m_stall, "R3", "no stall without cycle", 72'(m_stall), 72'(0));
      m_stb = 0;
      step();

      // write sweep over all windows, then aliased reads with random stall
      stall_en = 1;
      for (int k = 0; k < 8; k++)
         for (int s = 0; s < 4; s++)
            issue(1'b1, {2'(s), 18'(k * 37 + s)}, 16'hA000 ^ 16'(s << 8) ^ 16'(k));
      for (int k = 0; k < 8; k++)
         for (int s = 0; s < 4; s++)
            issue(1'b0, {2'(s), 10'(k + 5), 8'(k * 37 + s)}, 16'h0);   // R2 alias, R8 window 3
      for (int k = 0; k < 8; k++)
         issue(1'b0, {2'(k % 3), 18'(k * 37 + k % 3)}, 16'h0);
      drain();
      m_cyc = 0;
      stall_en = 0;
      repeat (3) step();

      // stall pass-through (R3)
      force_stall[1] = 1;
      step();
      m_cyc = 1; m_stb = 1; m_we = 0; m_adr = {2'd1, 18'd38}; #0.5;
      chk(m_stall == 1'b1, "R3", "slave stall reaches master", 72'(m_stall), 72'(1));
      chk(s_stb == 4'b0010, "R3", "stalling slave keeps strobe", 72'(s_stb), 72'(2));
      m_stb = 0;
      force_stall[1] = 0;
      step(); step();
      issue(1'b0, {2'd1, 18'd38}, 16'h0);
      drain();

      // slave switch guard (R10)
      issue(1'b0, {2'd2, 18'd39}, 16'h0);
      m_stb = 1; m_we = 0; m_adr = {2'd0, 18'd37}; #0.5;
      chk(m_stall == 1'b1, "R10", "switch stalls", 72'(m_stall), 72'(1));
      chk(s_stb == 4'b0, "R10", "switch strobes nothing", 72'(s_stb), 72'(0));
      issue(1'b0, {2'd0, 18'd37}, 16'h0);
      drain();

      // queue full (R9)
      for (int k = 0; k < 4; k++) issue(1'b0, {2'd2, 18'(k * 37 + 2)}, 16'h0);
      m_stb = 1; m_we = 0; m_adr = {2'd2, 18'd150}; #0.5;
      chk(m_stall == 1'b1, "R9", "full queue stalls", 72'(m_stall), 72'(1));
      chk(s_stb == 4'b0, "R9", "full queue strobes nothing", 72'(s_stb), 72'(0));
      issue(1'b0, {2'd2, 18'd150}, 16'h0);
      drain();

      // cycle drop flushes, late acks ignored (R6, R5)
      issue(1'b0, {2'd2, 18'd2}, 16'h0);
      issue(1'b0, {2'd2, 18'd39}, 16'h0);
      m_cyc = 0; eh = et;
      for (int n = 0; n < 8; n++) begin
         step();
         chk(!m_ack, "R6", "late ack after cycle drop", 72'(m_ack), 72'(0));
      end
      issue(1'b0, {2'd0, 18'd0}, 16'h0);
      drain();

      // reset mid-flight empties the queue (R6)
      issue(1'b0, {2'd2, 18'd2}, 16'h0);
      issue(1'b0, {2'd2, 18'd39}, 16'h0);
      rst = 1; eh = et;
      step();
      rst = 0;
      for (int n = 0; n < 8; n++) begin
         step();
         chk(!m_ack, "R6", "no ack after reset", 72'(m_ack), 72'(0));
      end
      issue(1'b0, {2'd1, 18'd1}, 16'h0);
      drain();
      m_cyc = 0;
      step();

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule